// File: doc/BRIEF.md
# Card Access Strobe Timing Sequencer

This block runs one host access to a removable card through a mapped window. The host presents a 20-bit offset inside a 1 MB window, a read/write flag and a request. The block then forms the 26-bit card address from the window's page number and the offset. It raises the select line for the addressed space: attribute memory, common memory or I/O. It then walks a three-phase timing sequence: address setup, command strobe, recovery. At the end it acknowledges the host with a one-clock pulse.

Two 16-bit window words set every timing value. The first word holds the strobe length, the setup delay, the space code and the page number. The second word holds the recovery delay, the wait-sampling delay and a flag that makes the card's active-low wait input stretch the strobe. A built-in watchdog ends a strobe that the card holds in wait for too long. An illegal space code is rejected at once, with no card cycle.

Top module: `card_strobe_seq`

## Requirements
- R1: After reset, and while no access is in progress, `ack`, `ack_err`, `rd_stb`, `wr_stb`, `timeout` and all three space selects are low.
- R2: During an access `card_addr` equals the page number (`win_ctl0` bits 5:0) in bits 25:20 and the offset `req_off` in bits 19:0.
- R3: The space code in `win_ctl0` bits 7:6 picks the select line: 00 raises `sel_attr`, 01 raises `sel_comm` and 10 raises `sel_io`. Exactly that one line is high from the first setup clock to the last recovery clock.
- R4: Space code 11 makes the block acknowledge in the clock after the request is accepted, with `ack_err` high. No strobe and no select rises.
- R5: Setup lasts (delay+1) clocks, with the delay in `win_ctl0` bits 9:8. The strobe lasts (length+1) clocks, with the length in `win_ctl0` bits 14:10. Recovery lasts (recovery+1) clocks, with the recovery in `win_ctl1` bits 4:3. `ack` then stays high for exactly one clock.
- R6: With `req_wr` = 1 only `wr_stb` pulses; with `req_wr` = 0 only `rd_stb` pulses. The two are never high together.
- R7: When `win_ctl1` bit 0 is set, `card_wait_n` is first sampled at the end of strobe clock (wdly+1), with wdly in `win_ctl1` bits 2:1. The strobe ends at the first clock end at which all three hold: the nominal length has elapsed, the sampling point has been reached, and `card_wait_n` is high.
- R8: When `win_ctl1` bit 0 is clear, `card_wait_n` has no effect on the strobe length.
- R9: A strobe that reaches 256 clocks ends. `timeout` pulses for one clock, recovery follows, and the access is acknowledged with `ack_err` high.
- R10: `card_addr` and the select lines do not change from the first setup clock to the last recovery clock.
- R11: An access that completes without a timeout acknowledges with `ack_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_ctl0 | input | 16 | Window word: length, setup delay, space code, page |
| win_ctl1 | input | 16 | Window word: recovery, wait delay, wait enable |
| req | input | 1 | Access request, held until `ack` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_off | input | 20 | Offset inside the 1 MB window |
| ack | output | 1 | One-clock completion pulse |
| ack_err | output | 1 | Error qualifier, valid with `ack` |
| card_addr | output | 26 | Card address |
| sel_attr | output | 1 | Attribute memory select |
| sel_comm | output | 1 | Common memory select |
| sel_io | output | 1 | I/O space select |
| rd_stb | output | 1 | Read command strobe |
| wr_stb | output | 1 | Write command strobe |
| card_wait_n | input | 1 | Active-low wait from the card |
| timeout | output | 1 | One-clock pulse when the watchdog ends a strobe |

## Verification
Accesses are run with minimum and maximum timing fields, so an off-by-one in any phase shows up as a wrong strobe count or a wrong acknowledge latency. Each space code and both directions are used, with pages and offsets chosen so that every address bit is exercised. The wait cases release the card at different points: before the sampling clock, after the nominal end, and never. These cases separate a sampling delay applied wrongly from a wait input that is ignored or honoured when disabled. The stuck-wait case forces the 256-clock watchdog.

// File: rtl/cstb_pkg.sv
package cstb_pkg;
   localparam int WORD_W = 16;
   localparam int LEN_W  = 5;
   localparam int DLY_W  = 2;

   typedef enum logic [2:0] {
      PH_IDLE, PH_SETUP, PH_STROBE, PH_RECOVER, PH_ACK
   } phase_e;

   typedef enum logic [1:0] {
      SP_ATTR = 2'b00, SP_COMMON = 2'b01, SP_IO = 2'b10, SP_BAD = 2'b11
   } space_e;

   typedef struct packed {
      logic [LEN_W-1:0] len;
      logic [DLY_W-1:0] dly;
      space_e           space;
      logic [1:0]       rec;
      logic [1:0]       wdly;
      logic             wait_en;
   } win_cfg_t;
endpackage

// File: rtl/cstb_cfg_decode.sv
module cstb_cfg_decode
   import cstb_pkg::*;
#(
   parameter int PAGE_W = 6
) (
   input  logic [WORD_W-1:0] ctl0,
   input  logic [WORD_W-1:0] ctl1,
   output win_cfg_t          cfg,
   output logic [PAGE_W-1:0] page
);
   localparam int LEN_LSB = 10;
   localparam int DLY_LSB = 8;
   localparam int SP_LSB  = 6;

   generate
      if (PAGE_W < 1 || PAGE_W > SP_LSB) begin : g_bad_page
         $error("PAGE_W must be between 1 and 6");
      end
   endgenerate

   always_comb begin
      cfg.len     = ctl0[LEN_LSB +: LEN_W];
      cfg.dly     = ctl0[DLY_LSB +: DLY_W];
      cfg.space   = space_e'(ctl0[SP_LSB +: 2]);
      cfg.rec     = ctl1[4:3];
      cfg.wdly    = ctl1[2:1];
      cfg.wait_en = ctl1[0];
      page        = ctl0[PAGE_W-1:0];
   end
endmodule

// File: rtl/cstb_phase_timer.sv
module cstb_phase_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !done) |=> (cnt < $past(cnt))); // R5
endmodule

// File: rtl/cstb_wait_guard.sv
module cstb_wait_guard #(
   parameter int WDOG = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_strobe,
   input  logic       nominal_done,
   input  logic       wait_en,
   input  logic [1:0] wdly,
   input  logic       wait_n,
   output logic       release_ok,
   output logic       expire
);
   localparam int SC_W = $clog2(WDOG) + 1;
   localparam logic [SC_W-1:0] SC_LAST = SC_W'(WDOG - 1);

   generate
      if (WDOG < 40) begin : g_bad_wdog
         $error("WDOG must exceed the longest nominal strobe");
      end
   endgenerate

   logic [SC_W-1:0] sc;   // strobe clocks already completed

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sc <= '0;
      else if (!in_strobe) sc <= '0;
      else if (sc != SC_LAST) sc <= sc + 1'b1;
   end

   always_comb begin
      release_ok = nominal_done &&
                   (!wait_en || ((sc >= SC_W'(wdly)) && wait_n));
      expire     = in_strobe && !release_ok && (sc == SC_LAST);
   end

   AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      in_strobe |-> (sc <= SC_LAST)); // R9
   AST_NO_WAIT_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_strobe && !wait_en && nominal_done) |-> release_ok); // R8
endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq
   import cstb_pkg::*;
#(
   parameter int OFF_W  = 20,
   parameter int PAGE_W = 6,
   parameter int WDOG   = 256
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [15:0]              win_ctl0,
   input  logic [15:0]              win_ctl1,
   input  logic                     req,
   input  logic                     req_wr,
   input  logic [OFF_W-1:0]         req_off,
   output logic                     ack,
   output logic                     ack_err,
   output logic [PAGE_W+OFF_W-1:0]  card_addr,
   output logic                     sel_attr,
   output logic                     sel_comm,
   output logic                     sel_io,
   output logic                     rd_stb,
   output logic                     wr_stb,
   input  logic                     card_wait_n,
   output logic                     timeout
);
   localparam int ADDR_W = PAGE_W + OFF_W;
   localparam int N_SP   = 3;

   generate
      if (OFF_W < 1) begin : g_bad_off
         $error("OFF_W must be positive");
      end
   endgenerate

   win_cfg_t          cfg_in, cfg_q;
   logic [PAGE_W-1:0] page_in;
   phase_e            phase;
   logic              wr_q, err_q, to_q;
   logic              tmr_load, tmr_done;
   logic [LEN_W-1:0]  tmr_val;
   logic              rel_ok, expire, active;
   logic [N_SP-1:0]   sel_vec;

   cstb_cfg_decode #(.PAGE_W(PAGE_W)) u_dec (
      .ctl0(win_ctl0), .ctl1(win_ctl1), .cfg(cfg_in), .page(page_in)
   );

   // Timer load points: accept, setup end and strobe end.
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (phase)
         PH_IDLE:    begin tmr_load = req; tmr_val = LEN_W'(cfg_in.dly); end
         PH_SETUP:   begin tmr_load = tmr_done; tmr_val = cfg_q.len; end
         PH_STROBE:  begin tmr_load = rel_ok || expire; tmr_val = LEN_W'(cfg_q.rec); end
         default:    begin tmr_load = 1'b0; tmr_val = '0; end
      endcase
   end

   cstb_phase_timer #(.CNT_W(LEN_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
   );

   cstb_wait_guard #(.WDOG(WDOG)) u_wait (
      .clk(clk), .rst_n(rst_n),
      .in_strobe(phase == PH_STROBE),
      .nominal_done(tmr_done),
      .wait_en(cfg_q.wait_en),
      .wdly(cfg_q.wdly),
      .wait_n(card_wait_n),
      .release_ok(rel_ok),
      .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cfg_q     <= '0;
         card_addr <= '0;
         wr_q      <= 1'b0;
         err_q     <= 1'b0;
         to_q      <= 1'b0;
      end else begin
         to_q <= 1'b0;
         unique case (phase)
            PH_IDLE: if (req) begin
               cfg_q     <= cfg_in;
               card_addr <= {page_in, req_off};
               wr_q      <= req_wr;
               err_q     <= (cfg_in.space == SP_BAD);
               phase     <= (cfg_in.space == SP_BAD) ? PH_ACK : PH_SETUP;
            end
            PH_SETUP:   if (tmr_done) phase <= PH_STROBE;
            PH_STROBE: begin
               if (rel_ok) begin
                  phase <= PH_RECOVER;
               end else if (expire) begin
                  phase <= PH_RECOVER;
                  err_q <= 1'b1;
                  to_q  <= 1'b1;
               end
            end
            PH_RECOVER: if (tmr_done) phase <= PH_ACK;
            default:    phase <= PH_IDLE;
         endcase
      end
   end

   assign active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_RECOVER);

   genvar gi;
   generate
      for (gi = 0; gi < N_SP; gi++) begin : g_sel
         assign sel_vec[gi] = active && (cfg_q.space == space_e'(gi));
      end
   endgenerate

   assign sel_attr = sel_vec[0];
   assign sel_comm = sel_vec[1];
   assign sel_io   = sel_vec[2];
   assign rd_stb   = (phase == PH_STROBE) && !wr_q;
   assign wr_stb   = (phase == PH_STROBE) &&  wr_q;
   assign ack      = (phase == PH_ACK);
   assign ack_err  = ack && err_q;
   assign timeout  = to_q;

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_vec)); // R3
   AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && wr_stb)); // R6
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> (!active || ($stable(card_addr) && $stable(sel_vec)))); // R10
   AST_ILLEGAL_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && req && win_ctl0[7:6] == 2'b11)
         |=> (ack && ack_err && sel_vec == '0)); // R4
   AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R5
   AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout); // R9
   AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_stb || wr_stb) |-> $past(phase == PH_SETUP)); // R5
endmodule

// File: tb/card_strobe_seq_test.sv
module card_strobe_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] win_ctl0 = '0, win_ctl1 = '0;
   logic        req = 1'b0, req_wr = 1'b0;
   logic [19:0] req_off = '0;
   logic        ack, ack_err, sel_attr, sel_comm, sel_io, rd_stb, wr_stb, timeout;
   logic [25:0] card_addr;
   logic        card_wait_n = 1'b1;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   card_strobe_seq uut (
      .clk(clk), .rst_n(rst_n), .win_ctl0(win_ctl0), .win_ctl1(win_ctl1),
      .req(req), .req_wr(req_wr), .req_off(req_off), .ack(ack), .ack_err(ack_err),
      .card_addr(card_addr), .sel_attr(sel_attr), .sel_comm(sel_comm), .sel_io(sel_io),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .card_wait_n(card_wait_n), .timeout(timeout)
   );

   typedef struct packed {
      logic [1:0]  dly;
      logic [4:0]  len;
      logic [1:0]  rec;
      logic [1:0]  sp;
      logic [5:0]  page;
      logic [19:0] off;
      logic        wr;
      logic        wen;
      logic [1:0]  wdly;
      logic [15:0] rel;     // strobe sample at which wait is released; 0 = never low, FFFF = never released
      logic [15:0] exp_stb;
      logic        exp_err;
      logic        exp_to;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 5'd0,  2'd0, 2'b00, 6'd0,  20'h00000, 1'b0, 1'b0, 2'd0, 16'd0,      16'd1,   1'b0, 1'b0},
      '{2'd3, 5'd31, 2'd3, 2'b01, 6'd63, 20'hFFFFF, 1'b1, 1'b0, 2'd0, 16'd0,      16'd32,  1'b0, 1'b0},
      '{2'd1, 5'd4,  2'd2, 2'b10, 6'd21, 20'h12345, 1'b0, 1'b0, 2'd0, 16'd0,      16'd5,   1'b0, 1'b0},
      '{2'd2, 5'd3,  2'd1, 2'b11, 6'd5,  20'h0ABCD, 1'b0, 1'b0, 2'd0, 16'd0,      16'd0,   1'b1, 1'b0},
      '{2'd0, 5'd2,  2'd0, 2'b01, 6'd42, 20'h5A5A5, 1'b1, 1'b1, 2'd1, 16'd6,      16'd6,   1'b0, 1'b0},
      '{2'd1, 5'd0,  2'd1, 2'b00, 6'd1,  20'hA5A5A, 1'b0, 1'b1, 2'd3, 16'd1,      16'd4,   1'b0, 1'b0},
      '{2'd0, 5'd3,  2'd0, 2'b10, 6'd10, 20'h00F0F, 1'b1, 1'b0, 2'd2, 16'hFFFF,   16'd4,   1'b0, 1'b0},
      '{2'd0, 5'd1,  2'd2, 2'b01, 6'd33, 20'h80001, 1'b0, 1'b1, 2'd0, 16'hFFFF,   16'd256, 1'b1, 1'b1},
      '{2'd1, 5'd5,  2'd0, 2'b00, 6'd12, 20'h33333, 1'b1, 1'b1, 2'd0, 16'd2,      16'd6,   1'b0, 1'b0}
   };

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      int n = 0, s = 0, tcnt = 0, sel_bad = 0, addr_bad = 0, both = 0, dir_bad = 0, addr_moves = 0;
      int exp_lat;
      logic [25:0] exp_addr, first_addr;
      bit seen = 0;
      logic [2:0] exp_sel;
      exp_addr = {v.page, v.off};
      exp_sel  = (v.sp == 2'b00) ? 3'b001 : (v.sp == 2'b01) ? 3'b010 : (v.sp == 2'b10) ? 3'b100 : 3'b000;
      exp_lat  = (v.sp == 2'b11) ? 1 : (int'(v.dly) + 1) + int'(v.exp_stb) + (int'(v.rec) + 1) + 1;
      @(negedge clk);
      win_ctl0    = {1'b0, v.len, v.dly, v.sp, v.page};
      win_ctl1    = {11'b0, v.rec, v.wdly, v.wen};
      req_off     = v.off;
      req_wr      = v.wr;
      card_wait_n = (v.rel == 16'd0);
      req         = 1'b1;
      do begin
         @(negedge clk);
         n++;
         if (rd_stb || wr_stb) begin
            s++;
            if (rd_stb && wr_stb) both++;
            if (wr_stb != v.wr) dir_bad++;
            if (v.rel != 16'd0 && v.rel != 16'hFFFF && s >= int'(v.rel)) card_wait_n = 1'b1;
         end
         if (timeout) tcnt++;
         if (!ack) begin
            if ({sel_io, sel_comm, sel_attr} != exp_sel) sel_bad++;
            if (exp_sel != 3'b000) begin
               if (card_addr != exp_addr) addr_bad++;
               if (seen && card_addr != first_addr) addr_moves++;
               if (!seen) begin first_addr = card_addr; seen = 1; end
            end
         end
      end while (!ack && n < 2000);
      chk(n == exp_lat, $sformatf("R5 vec%0d ack latency", idx), n, exp_lat);
      chk(s == int'(v.exp_stb), $sformatf("R7 R8 R9 vec%0d strobe clocks", idx), s, v.exp_stb);
      chk(ack_err == v.exp_err, $sformatf("R4 R11 vec%0d ack_err", idx), ack_err, v.exp_err);
      chk(tcnt == int'(v.exp_to), $sformatf("R9 vec%0d timeout pulses", idx), tcnt, v.exp_to);
      chk(sel_bad == 0, $sformatf("R3 vec%0d select lines", idx), sel_bad, 0);
      chk(addr_bad == 0, $sformatf("R2 vec%0d card address", idx), addr_bad, 0);
      chk(addr_moves == 0, $sformatf("R10 vec%0d address stable", idx), addr_moves, 0);
      chk(both == 0 && dir_bad == 0, $sformatf("R6 vec%0d strobe direction", idx), both + dir_bad, 0);
      req = 1'b0;
      card_wait_n = 1'b1;
      @(negedge clk);
      chk(!ack && !rd_stb && !wr_stb, $sformatf("R1 R5 vec%0d idle after ack", idx), ack, 0);
   endtask

   initial begin : watchdog
      #500000;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk({ack, ack_err, rd_stb, wr_stb, timeout, sel_attr, sel_comm, sel_io} == 8'b0,
          "R1 outputs in reset", {ack, rd_stb, wr_stb}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk({ack, ack_err, rd_stb, wr_stb, timeout, sel_attr, sel_comm, sel_io} == 8'b0,
          "R1 outputs idle after reset", {ack, rd_stb, wr_stb}, 0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

      // R8: wait low with wait disabled, long strobe, direction write
      run_vec('{2'd2, 5'd9, 2'd1, 2'b10, 6'd7, 20'hC0FFE, 1'b1, 1'b0, 2'd3, 16'hFFFF, 16'd10, 1'b0, 1'b0}, 100);

      // R1: reset in the middle of a strobe returns outputs low
      @(negedge clk);
      win_ctl0 = {1'b0, 5'd20, 2'd0, 2'b01, 6'd3};
      win_ctl1 = 16'h0;
      req_wr = 1'b1;
      req = 1'b1;
      repeat (4) @(negedge clk);
      chk(wr_stb == 1'b1, "R5 strobe active before reset", wr_stb, 1);
      rst_n = 1'b0;
      req = 1'b0;
      #1;
      chk({wr_stb, sel_comm, ack} == 3'b0, "R1 outputs cleared by reset", {wr_stb, sel_comm}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({ack, wr_stb, rd_stb, timeout} == 4'b0, "R1 idle after mid-access reset", ack, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule